// File: doc/BRIEF.md
# Floating-Point Min/Max Selector with Magnitude Modes

This block picks one of two binary32 operands according to a 2-bit operation code. It offers ordinary signed minimum and maximum, and the magnitude variants that choose by absolute value. It is purely combinational. It does no arithmetic, so neither operand is ever altered. It decides by classifying both bit patterns and comparing their sign and magnitude fields. The result is always, bit for bit, one of the two inputs.

NaN inputs follow a fixed rule. A numeric operand is preferred over a NaN. When both operands are NaN, the first operand wins. The signed ordering treats the two zeros as equal. When the magnitude operations see two operands of equal absolute value, they return the operand that is larger as a signed value. A scheduler or execute stage drives the operands and the code and takes the result in the same cycle.

Top module: `fp_minmax_sel`

## Requirements
- R1: When both `fs_i` and `ft_i` are NaN (exponent all ones, fraction non-zero), `res_o` equals `fs_i` exactly, for every operation code.
- R2: When only `fs_i` is NaN, `res_o` equals `ft_i`, for every operation code.
- R3: When only `ft_i` is NaN, `res_o` equals `fs_i`, for every operation code.
- R4: With `op_i` = 0 (minimum) and no NaN, `res_o` is `ft_i` when `fs_i` ≥ `ft_i` as signed values, otherwise `fs_i`.
- R5: With `op_i` = 1 (maximum) and no NaN, `res_o` is `ft_i` when `fs_i` ≤ `ft_i` as signed values, otherwise `fs_i`.
- R6: +0.0 (0x00000000) and -0.0 (0x80000000) compare equal, so minimum and maximum of a signed-zero pair both return `ft_i`.
- R7: With `op_i` = 2 (minimum magnitude) and no NaN, `res_o` is the operand with the strictly smaller absolute value (bits 30:0).
- R8: With `op_i` = 3 (maximum magnitude) and no NaN, `res_o` is the operand with the strictly larger absolute value.
- R9: When the absolute values are equal, codes 2 and 3 both return the operand that is larger as a signed value. If the two are equal as signed values too (as with the signed zeros), they return `ft_i`.
- R10: Infinities (exponent all ones, fraction zero) are ordered as ordinary values, beyond every finite value of the same sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fs_i | input | 32 | First operand, binary32 bit pattern |
| ft_i | input | 32 | Second operand, binary32 bit pattern |
| op_i | input | 2 | Operation: 0 min, 1 max, 2 min-magnitude, 3 max-magnitude |
| res_o | output | 32 | Selected operand |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit fraction and 8-bit comparator slices. The 31-bit magnitude therefore splits into four slices, and the top slice is only partly filled. Directed operand pairs are chosen so that they differ only in the lowest slice, only in the exponent, or only in sign. The pairs also include the signed zeros, a subnormal, both infinities and two distinct NaN payloads. Together these reach every branch of the slice chaining and of the NaN and tie priority.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    typedef enum logic [1:0] {
        OP_MIN    = 2'd0,
        OP_MAX    = 2'd1,
        OP_MINMAG = 2'd2,
        OP_MAXMAG = 2'd3
    } fpmm_op_e;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_zero;
    } fpmm_cls_t;

    typedef struct packed {
        logic lt;
        logic eq;
    } fpmm_cmp_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [W-1:0]     val_i,
    output fpmm_cls_t        cls_o,
    output logic [MAG_W-1:0] mag_o
);

    fpmm_cls_t cls_d;

    always_comb begin
        cls_d.sign    = val_i[W-1];
        cls_d.is_nan  = (&val_i[MAG_W-1:MAN_W]) && (|val_i[MAN_W-1:0]);
        cls_d.is_zero = ~(|val_i[MAG_W-1:0]);
    end

    assign cls_o = cls_d;
    assign mag_o = val_i[MAG_W-1:0];

endmodule

// File: rtl/fpmm_mag_cmp.sv
module fpmm_mag_cmp
    import fpmm_pkg::*;
#(
    parameter int MAG_W   = 31,
    parameter int CHUNK_W = 8,
    localparam int N_CHUNK = (MAG_W + CHUNK_W - 1) / CHUNK_W,
    localparam int PAD_W   = N_CHUNK * CHUNK_W
) (
    input  logic [MAG_W-1:0] a_i,
    input  logic [MAG_W-1:0] b_i,
    output fpmm_cmp_t        cmp_o
);

    logic [PAD_W-1:0]   a_pad, b_pad;
    logic [N_CHUNK-1:0] slice_lt, slice_eq;
    fpmm_cmp_t          cmp_d;

    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[MAG_W-1:0] = a_i;
        b_pad[MAG_W-1:0] = b_i;
    end

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_slice
        assign slice_lt[g] = a_pad[g*CHUNK_W +: CHUNK_W] <  b_pad[g*CHUNK_W +: CHUNK_W];
        assign slice_eq[g] = a_pad[g*CHUNK_W +: CHUNK_W] == b_pad[g*CHUNK_W +: CHUNK_W];
    end

    // Most significant slice decides; lower slices only matter while all above tie.
    always_comb begin
        cmp_d.lt = 1'b0;
        cmp_d.eq = 1'b1;
        for (int i = N_CHUNK - 1; i >= 0; i--) begin
            cmp_d.lt = cmp_d.lt | (cmp_d.eq & slice_lt[i]);
            cmp_d.eq = cmp_d.eq & slice_eq[i];
        end
    end

    assign cmp_o = cmp_d;

endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
    import fpmm_pkg::*;
(
    input  fpmm_cls_t cls_a_i,
    input  fpmm_cls_t cls_b_i,
    input  fpmm_cmp_t mag_i,
    output fpmm_cmp_t sgn_o
);

    fpmm_cmp_t sgn_d;

    always_comb begin
        if (cls_a_i.is_zero && cls_b_i.is_zero) begin
            sgn_d.lt = 1'b0;
            sgn_d.eq = 1'b1;
        end else if (cls_a_i.sign != cls_b_i.sign) begin
            sgn_d.lt = cls_a_i.sign;
            sgn_d.eq = 1'b0;
        end else if (!cls_a_i.sign) begin
            sgn_d.lt = mag_i.lt;
            sgn_d.eq = mag_i.eq;
        end else begin
            sgn_d.lt = ~mag_i.lt & ~mag_i.eq;
            sgn_d.eq = mag_i.eq;
        end
    end

    assign sgn_o = sgn_d;

endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
    import fpmm_pkg::*;
#(
    parameter int W = 32
) (
    input  fpmm_op_e     op_i,
    input  logic [W-1:0] fs_i,
    input  logic [W-1:0] ft_i,
    input  fpmm_cls_t    cls_s_i,
    input  fpmm_cls_t    cls_t_i,
    input  fpmm_cmp_t    mag_i,
    input  fpmm_cmp_t    sgn_i,
    output logic [W-1:0] res_o
);

    typedef struct packed {
        logic take_ft;
    } pick_t;

    pick_t pick_d;
    logic  mag_gt, sgn_gt, tie_take_ft;

    always_comb begin
        mag_gt      = ~mag_i.lt & ~mag_i.eq;
        sgn_gt      = ~sgn_i.lt & ~sgn_i.eq;
        tie_take_ft = ~sgn_gt;
        pick_d.take_ft = 1'b0;
        if (cls_s_i.is_nan && cls_t_i.is_nan) begin
            pick_d.take_ft = 1'b0;
        end else if (cls_s_i.is_nan) begin
            pick_d.take_ft = 1'b1;
        end else if (cls_t_i.is_nan) begin
            pick_d.take_ft = 1'b0;
        end else begin
            unique case (op_i)
                OP_MIN:    pick_d.take_ft = ~sgn_i.lt;
                OP_MAX:    pick_d.take_ft = sgn_i.lt | sgn_i.eq;
                OP_MINMAG: pick_d.take_ft = mag_gt  | (mag_i.eq & tie_take_ft);
                OP_MAXMAG: pick_d.take_ft = mag_i.lt | (mag_i.eq & tie_take_ft);
                default:   pick_d.take_ft = 1'b0;
            endcase
        end
    end

    assign res_o = pick_d.take_ft ? ft_i : fs_i;

    always_comb begin
        if (!cls_s_i.is_nan && !cls_t_i.is_nan && op_i == OP_MIN
            && cls_s_i.sign != cls_t_i.sign && !(cls_s_i.is_zero && cls_t_i.is_zero)) begin
            AST_MIN_TAKES_NEGATIVE: assert (res_o[W-1]) else $error("min kept positive"); // R4
        end
        if (!cls_s_i.is_nan && !cls_t_i.is_nan && op_i == OP_MAX
            && cls_s_i.sign != cls_t_i.sign && !(cls_s_i.is_zero && cls_t_i.is_zero)) begin
            AST_MAX_TAKES_POSITIVE: assert (!res_o[W-1]) else $error("max kept negative"); // R5
        end
    end

endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
    import fpmm_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int CHUNK_W = 8,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [W-1:0] fs_i,
    input  logic [W-1:0] ft_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] res_o
);

    logic [W-1:0]     opnd   [2];
    fpmm_cls_t        cls    [2];
    logic [MAG_W-1:0] mag    [2];
    fpmm_cmp_t        mag_cmp, sgn_cmp;
    fpmm_op_e         op_d;

    assign opnd[0] = fs_i;
    assign opnd[1] = ft_i;
    assign op_d    = fpmm_op_e'(op_i);

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val_i (opnd[g]),
            .cls_o (cls[g]),
            .mag_o (mag[g])
        );
    end

    fpmm_mag_cmp #(.MAG_W(MAG_W), .CHUNK_W(CHUNK_W)) u_mag (
        .a_i   (mag[0]),
        .b_i   (mag[1]),
        .cmp_o (mag_cmp)
    );

    fpmm_order u_ord (
        .cls_a_i (cls[0]),
        .cls_b_i (cls[1]),
        .mag_i   (mag_cmp),
        .sgn_o   (sgn_cmp)
    );

    fpmm_pick #(.W(W)) u_pick (
        .op_i    (op_d),
        .fs_i    (fs_i),
        .ft_i    (ft_i),
        .cls_s_i (cls[0]),
        .cls_t_i (cls[1]),
        .mag_i   (mag_cmp),
        .sgn_i   (sgn_cmp),
        .res_o   (res_o)
    );

    always_comb begin
        if (cls[0].is_nan && cls[1].is_nan) begin
            AST_BOTH_NAN_KEEPS_FS: assert (res_o == fs_i) else $error("both NaN"); // R1
        end
        if (cls[0].is_nan && !cls[1].is_nan) begin
            AST_FS_NAN_GIVES_FT: assert (res_o == ft_i) else $error("fs NaN"); // R2
        end
        if (!cls[0].is_nan && cls[1].is_nan) begin
            AST_FT_NAN_GIVES_FS: assert (res_o == fs_i) else $error("ft NaN"); // R3
        end
        if (!cls[0].is_nan && !cls[1].is_nan && op_i == 2'd2) begin
            AST_MINMAG_NOT_LARGER: assert (res_o[MAG_W-1:0] <= fs_i[MAG_W-1:0]
                                        && res_o[MAG_W-1:0] <= ft_i[MAG_W-1:0])
                else $error("minmag too large"); // R7
        end
        if (!cls[0].is_nan && !cls[1].is_nan && op_i == 2'd3) begin
            AST_MAXMAG_NOT_SMALLER: assert (res_o[MAG_W-1:0] >= fs_i[MAG_W-1:0]
                                         && res_o[MAG_W-1:0] >= ft_i[MAG_W-1:0])
                else $error("maxmag too small"); // R8
        end
    end

endmodule

// File: tb/fp_minmax_sel_tb.sv
module fp_minmax_sel_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] P0   = 32'h0000_0000;
    localparam logic [31:0] N0   = 32'h8000_0000;
    localparam logic [31:0] P1   = 32'h3F80_0000;
    localparam logic [31:0] N1   = 32'hBF80_0000;
    localparam logic [31:0] P2   = 32'h4000_0000;
    localparam logic [31:0] N2   = 32'hC000_0000;
    localparam logic [31:0] N3   = 32'hC040_0000;
    localparam logic [31:0] PH   = 32'h3F00_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;
    localparam logic [31:0] DNRM = 32'h0000_0001;
    localparam logic [31:0] P1UP = 32'h3F80_0001;

    logic        clk = 1'b0;
    logic [31:0] fs, ft, res;
    logic [1:0]  op;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_minmax_sel dut_i (
        .fs_i  (fs),
        .ft_i  (ft),
        .op_i  (op),
        .res_o (res)
    );

    task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_v, input string tag);
        @(negedge clk);
        op = o; fs = a; ft = b;
        @(posedge clk);
        #1;
        n_run++;
        if (res !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d fs=%h ft=%h actual=%h expected=%h", tag, o, a, b, res, exp_v);
        end
    endtask

    task automatic t_idle();
        #1;
        n_run++;
        if (res !== P0) begin
            n_fail++;
            $display("FAIL R6 idle actual=%h expected=%h", res, P0);
        end
    endtask

    task automatic t_both_nan();
        for (int o = 0; o < 4; o++) begin
            apply(2'(o), QNAN, SNAN, QNAN, "R1");
            apply(2'(o), SNAN, QNAN, SNAN, "R1");
        end
    endtask

    task automatic t_one_nan();
        for (int o = 0; o < 4; o++) begin
            apply(2'(o), QNAN, N2, N2, "R2");
            apply(2'(o), P1, SNAN, P1, "R3");
        end
    endtask

    task automatic t_min();
        apply(2'd0, P1, P2, P1, "R4");
        apply(2'd0, P2, P1, P1, "R4");
        apply(2'd0, N1, P2, N1, "R4");
        apply(2'd0, N3, N2, N3, "R4");
        apply(2'd0, DNRM, P0, P0, "R4");
        apply(2'd0, P1UP, P1, P1, "R4");
    endtask

    task automatic t_max();
        apply(2'd1, P1, P2, P2, "R5");
        apply(2'd1, N3, N2, N2, "R5");
        apply(2'd1, N1, PH, PH, "R5");
        apply(2'd1, P1, P1UP, P1UP, "R5");
    endtask

    task automatic t_zeros();
        apply(2'd0, P0, N0, N0, "R6");
        apply(2'd0, N0, P0, P0, "R6");
        apply(2'd1, P0, N0, N0, "R6");
        apply(2'd1, N0, P0, P0, "R6");
    endtask

    task automatic t_minmag();
        apply(2'd2, N3, P2, P2, "R7");
        apply(2'd2, PH, N1, PH, "R7");
        apply(2'd2, NINF, P1, P1, "R7");
    endtask

    task automatic t_maxmag();
        apply(2'd3, N3, P2, N3, "R8");
        apply(2'd3, PH, N1, N1, "R8");
        apply(2'd3, N1, DNRM, N1, "R8");
    endtask

    task automatic t_ties();
        apply(2'd2, P2, N2, P2, "R9");
        apply(2'd2, N2, P2, P2, "R9");
        apply(2'd3, N2, P2, P2, "R9");
        apply(2'd3, P2, N2, P2, "R9");
        apply(2'd3, P0, N0, N0, "R9");
        apply(2'd2, N0, P0, P0, "R9");
    endtask

    task automatic t_inf();
        apply(2'd0, NINF, N3, NINF, "R10");
        apply(2'd1, PINF, P2, PINF, "R10");
        apply(2'd1, NINF, PINF, PINF, "R10");
        apply(2'd2, PINF, N3, N3, "R10");
    endtask

    initial begin
        op = 2'd0; fs = P0; ft = P0;
        t_idle();
        t_both_nan();
        t_one_nan();
        t_min();
        t_max();
        t_zeros();
        t_minmag();
        t_maxmag();
        t_ties();
        t_inf();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule